// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block divides a stream of VCO-side events by a programmable total ratio. The divider is built the classic dual-modulus way. A prescaler counts VCO events modulo M or M+1. An 11-bit main counter counts prescaler cycles. A 7-bit swallow counter holds the prescaler at M+1 for the first A of those cycles, which gives a total of M·N + A events per output period. A separate 14-bit counter divides reference events by R to produce the comparison reference. Both results leave the block as single-cycle pulses. Together they set the synthesized relation fvco = (M·N + A)·fref / R.

All counting runs on one system clock. The VCO and reference sides arrive as clock enables (`vco_ce`, `ref_ce`), one per modelled input edge. The base modulus pair is fixed per instance by a channel parameter: 16/32 for the low-band channel and 64/128 for the high-band channel. A select input picks the member of the pair. The ratio inputs are live. They are sampled only when a period completes, so a change never produces a shortened or stretched period. While `en` is low, both counters hold at the start of a period and keep loading the current inputs. After reset, `en` must be low for at least one clock before counting starts.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With ratios N and A in force, `fp_pulse` fires once per M·N + A sampled `vco_ce` events. It is high for exactly the one clock that follows the edge that sampled the final event.
- R2: M is 16 when `sw_sel`=0 and 32 when `sw_sel`=1 for `CHAN_RF`=0. It is 64 and 128 respectively for `CHAN_RF`=1. The prescaler cycle is M+1 events while swallowing and M otherwise.
- R3: `mod_hi` is high exactly while fewer than A·(M+1) events of the current period have been counted. It therefore covers the first A prescaler cycles, and it is low for the rest of the period and whenever A is 0.
- R4: `fr_pulse` fires once per R sampled `ref_ce` events. It is high for the single clock after the edge that sampled the R-th event.
- R5: `n_val`, `a_val` and `sw_sel` are taken only at the edge that ends a VCO period, and `r_val` only at the edge that ends a reference period. At any other time while `en` is high, a change has no effect on the period in progress.
- R6: When `a_val` ≥ effective N, `a_clamped` is high in the same cycle, and A = N−1 is used. Otherwise `a_clamped` is low and A = `a_val`.
- R7: An `n_val` below 5 is treated as 5, and an `r_val` below 5 is treated as 5.
- R8: While `en` is low, neither pulse fires. Both counters restart, loading the inputs present at each such edge. The first period counts from the first event sampled with `en` high.
- R9: During and right after reset, `fp_pulse`, `fr_pulse` and `mod_hi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| en | input | 1 | count enable; low holds and reloads both counters |
| vco_ce | input | 1 | one VCO-side event per sampled high cycle |
| ref_ce | input | 1 | one reference event per sampled high cycle |
| sw_sel | input | 1 | prescaler pair member select (0 small, 1 large) |
| n_val | input | 11 | main counter ratio N |
| a_val | input | 7 | swallow count A |
| r_val | input | 14 | reference ratio R |
| fp_pulse | output | 1 | divided VCO pulse, one clock wide |
| fr_pulse | output | 1 | divided reference pulse, one clock wide |
| mod_hi | output | 1 | modulus control: prescaler at M+1 |
| a_clamped | output | 1 | A was at or above effective N and has been clamped |

## Verification
The two pulses are registered. Each one becomes visible in the clock that follows the edge sampling the terminal event. `mod_hi` follows the swallow state, which also changes at an edge. `a_clamped` is combinational from the present inputs. The reference model advances its event positions at every rising edge from the same sampled inputs. It compares all four outputs a quarter period after the falling edge, after the inputs driven on that falling edge have settled. Each output is thus checked in the very cycle its value is due, with no slack. Stimulus randomizes both event streams and changes ratios in mid-period, which exercises the sampling boundaries of R5 and R8.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int N_W   = 11;
  localparam int A_W   = 7;
  localparam int R_W   = 14;
  localparam int PRE_W = 8;
  localparam int N_MIN = 5;
  localparam int R_MIN = 5;

  // base prescaler modulus for a channel and pair select
  function automatic logic [PRE_W-1:0] base_modulus(input logic chan_hi, input logic sw);
    logic [PRE_W-1:0] m;
    case ({chan_hi, sw})
      2'b00:   m = PRE_W'(16);
      2'b01:   m = PRE_W'(32);
      2'b10:   m = PRE_W'(64);
      default: m = PRE_W'(128);
    endcase
    return m;
  endfunction

  function automatic logic [N_W-1:0] floor_n(input logic [N_W-1:0] n);
    return (n < N_W'(N_MIN)) ? N_W'(N_MIN) : n;
  endfunction

  function automatic logic [R_W-1:0] floor_r(input logic [R_W-1:0] r);
    return (r < R_W'(R_MIN)) ? R_W'(R_MIN) : r;
  endfunction

  function automatic logic swallow_over(input logic [A_W-1:0] a, input logic [N_W-1:0] n_eff);
    return N_W'(a) >= n_eff;
  endfunction

  // only reached with n_eff <= a, so n_eff-1 fits in A_W bits
  function automatic logic [A_W-1:0] clamp_a(input logic [A_W-1:0] a, input logic [N_W-1:0] n_eff);
    logic [N_W-1:0] lim;
    lim = n_eff - N_W'(1);
    return swallow_over(a, n_eff) ? lim[A_W-1:0] : a;
  endfunction
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [PRE_W-1:0] modulus,
  output logic             cyc_end
);
  logic [PRE_W-1:0] cnt;

  assign cyc_end = step && (cnt == modulus - PRE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= '0;
    else if (cyc_end) cnt <= '0;
    else if (step)    cnt <= cnt + PRE_W'(1);
  end

  AST_PRE_WITHIN_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < modulus); // R2
endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr
  import psd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           pre_evt,
  input  logic [N_W-1:0] n_eff,
  input  logic [A_W-1:0] a_eff,
  input  logic           sw_in,
  output logic           swal_nz,
  output logic           msel,
  output logic           fp_pulse
);
  logic [N_W-1:0] prog_cnt;
  logic [A_W-1:0] swal_cnt;
  logic           period_end;

  assign period_end = pre_evt && (prog_cnt == N_W'(1));
  assign swal_nz    = (swal_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_cnt <= '0;
      swal_cnt <= '0;
      msel     <= 1'b0;
      fp_pulse <= 1'b0;
    end else if (load) begin
      prog_cnt <= n_eff;
      swal_cnt <= a_eff;
      msel     <= sw_in;
      fp_pulse <= 1'b0;
    end else begin
      fp_pulse <= period_end;
      if (period_end) begin
        prog_cnt <= n_eff;
        swal_cnt <= a_eff;
        msel     <= sw_in;
      end else if (pre_evt) begin
        prog_cnt <= prog_cnt - N_W'(1);
        if (swal_nz) swal_cnt <= swal_cnt - A_W'(1);
      end
    end
  end

  AST_PROG_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_cnt != '0) |=> (prog_cnt != '0)); // R1
  AST_FP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fp_pulse |=> !fp_pulse); // R1
  AST_SWAL_BELOW_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_cnt != '0) |-> (N_W'(swal_cnt) < prog_cnt)); // R6
  AST_MOD_FALL_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swal_nz) |-> ($past(pre_evt) || $past(load))); // R3
endmodule

// File: rtl/psd_ref_ctr.sv
module psd_ref_ctr
  import psd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [R_W-1:0] r_eff,
  output logic           fr_pulse
);
  logic [R_W-1:0] r_cur;
  logic [R_W-1:0] cnt;
  logic           ref_end;

  assign ref_end = step && (cnt == r_cur - R_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cur    <= '0;
      cnt      <= '0;
      fr_pulse <= 1'b0;
    end else if (load) begin
      r_cur    <= r_eff;
      cnt      <= '0;
      fr_pulse <= 1'b0;
    end else begin
      fr_pulse <= ref_end;
      if (ref_end) begin
        cnt   <= '0;
        r_cur <= r_eff;
      end else if (step) begin
        cnt <= cnt + R_W'(1);
      end
    end
  end

  AST_REF_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (r_cur != '0) |-> (cnt < r_cur)); // R4
  AST_FR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_pulse |=> !fr_pulse); // R4
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter bit CHAN_RF = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           vco_ce,
  input  logic           ref_ce,
  input  logic           sw_sel,
  input  logic [N_W-1:0] n_val,
  input  logic [A_W-1:0] a_val,
  input  logic [R_W-1:0] r_val,
  output logic           fp_pulse,
  output logic           fr_pulse,
  output logic           mod_hi,
  output logic           a_clamped
);
  logic [N_W-1:0]   n_eff;
  logic [A_W-1:0]   a_eff;
  logic [R_W-1:0]   r_eff;
  logic [PRE_W-1:0] modulus;
  logic             load;
  logic             vco_step;
  logic             ref_step;
  logic             pre_evt;
  logic             swal_nz;
  logic             msel;

  assign n_eff     = floor_n(n_val);
  assign a_eff     = clamp_a(a_val, n_eff);
  assign r_eff     = floor_r(r_val);
  assign a_clamped = swallow_over(a_val, n_eff);

  assign load     = !en;
  assign vco_step = en && vco_ce;
  assign ref_step = en && ref_ce;
  assign modulus  = base_modulus(CHAN_RF, msel) + PRE_W'(swal_nz);
  assign mod_hi   = swal_nz;

  psd_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (vco_step),
    .modulus (modulus),
    .cyc_end (pre_evt)
  );

  psd_swallow_ctr u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .pre_evt  (pre_evt),
    .n_eff    (n_eff),
    .a_eff    (a_eff),
    .sw_in    (sw_sel),
    .swal_nz  (swal_nz),
    .msel     (msel),
    .fp_pulse (fp_pulse)
  );

  psd_ref_ctr u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (ref_step),
    .r_eff    (r_eff),
    .fr_pulse (fr_pulse)
  );

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!fp_pulse && !fr_pulse)); // R8
  AST_EFF_N_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    n_eff >= N_W'(N_MIN)); // R7
endmodule

// File: tb/pulse_swallow_divider_test.sv
module pulse_swallow_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        vco_ce = 1'b0;
  logic        ref_ce = 1'b0;
  logic        sw_sel = 1'b0;
  logic [10:0] n_val = 11'd5;
  logic [6:0]  a_val = 7'd0;
  logic [13:0] r_val = 14'd5;
  logic        fp_pulse, fr_pulse, mod_hi, a_clamped;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_swallow_divider #(.CHAN_RF(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .vco_ce(vco_ce), .ref_ce(ref_ce),
    .sw_sel(sw_sel), .n_val(n_val), .a_val(a_val), .r_val(r_val),
    .fp_pulse(fp_pulse), .fr_pulse(fr_pulse), .mod_hi(mod_hi), .a_clamped(a_clamped)
  );

  // ---------------- behavioural reference ----------------
  function automatic int eff_n(int n);
    return (n < 5) ? 5 : n;
  endfunction
  function automatic int eff_r(int r);
    return (r < 5) ? 5 : r;
  endfunction
  function automatic int eff_a(int a, int n);
    return (a >= eff_n(n)) ? eff_n(n) - 1 : a;
  endfunction

  int  pos = 0, rpos = 0;
  int  mN = 0, mA = 0, mM = 16, mR = 0;
  bit  e_fp = 0, e_fr = 0;

  task automatic latch_vco;
    mN = eff_n(int'(n_val));
    mA = eff_a(int'(a_val), int'(n_val));
    mM = sw_sel ? 32 : 16;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = 0; rpos = 0; mN = 0; mA = 0; mM = 16; mR = 0; e_fp = 0; e_fr = 0;
    end else if (!en) begin
      latch_vco();
      mR = eff_r(int'(r_val));
      pos = 0; rpos = 0; e_fp = 0; e_fr = 0;
    end else begin
      e_fp = 0;
      if (vco_ce) begin
        pos++;
        if (pos == mM * mN + mA) begin
          e_fp = 1; pos = 0; latch_vco();
        end
      end
      e_fr = 0;
      if (ref_ce) begin
        rpos++;
        if (rpos == mR) begin
          e_fr = 1; rpos = 0; mR = eff_r(int'(r_val));
        end
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", what, $time, act, exp);
    end
  endtask

  // compare a quarter period after the falling edge
  always @(negedge clk) begin
    #2;
    chk(fp_pulse, e_fp, "R1/R2/R5/R7/R8/R9 fp_pulse");
    chk(fr_pulse, e_fr, "R4/R5/R7/R8/R9 fr_pulse");
    chk(mod_hi, (pos < mA * (mM + 1)), "R3/R9 mod_hi");
    chk(a_clamped, (int'(a_val) >= eff_n(int'(n_val))), "R6 a_clamped");
  end

  // random event streams
  bit ev_on = 1'b0;
  always @(negedge clk) begin
    vco_ce = ev_on && (($urandom % 4) != 0);
    ref_ce = ev_on && (($urandom % 3) != 0);
  end

  task automatic set_cfg(input int n, input int a, input bit sw, input int r);
    @(negedge clk);
    n_val = 11'(n); a_val = 7'(a); sw_sel = sw; r_val = 14'(r);
  endtask
  task automatic idle(input int k);
    en = 1'b0;
    repeat (k) @(negedge clk);
  endtask
  task automatic run(input int k);
    en = 1'b1;
    repeat (k) @(negedge clk);
  endtask

  initial begin
    ev_on = 1'b1;
    repeat (3) @(negedge clk);       // R9: reset state checked by compare block
    rst_n = 1'b1;
    idle(2);
    set_cfg(5, 0, 0, 5);   idle(2); run(800);    // R1 smallest period
    set_cfg(7, 3, 0, 9);   idle(2); run(1500);   // R3 swallow active
    set_cfg(6, 5, 1, 7);   idle(2); run(1500);   // R2 larger modulus, A = N-1
    set_cfg(9, 2, 0, 6);   idle(2); run(300);
    set_cfg(5, 1, 1, 13);  run(1500);            // R5 change mid-period
    set_cfg(6, 10, 0, 11); idle(2); run(1500);   // R6 clamp
    set_cfg(5, 5, 0, 5);   run(800);             // R6 boundary A == N
    set_cfg(2, 1, 0, 1);   idle(2); run(800);    // R7 floors
    set_cfg(0, 0, 1, 0);   idle(2); run(800);    // R7 zeros
    set_cfg(10, 4, 1, 17); idle(2); run(200);
    set_cfg(8, 7, 1, 20);  idle(20); run(1500);  // R8 restart mid-period
    set_cfg(200, 127, 0, 300); idle(2); run(5000); // R3 widest swallow
    idle(5);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule